// File: doc/BRIEF.md
# Clock Manager Reset and Health Monitor

This block supervises an on-chip clock manager (a delay-locked or phase-locked clock generator). It runs only from a free-running reference clock and never from any clock the manager produces, so a failed manager cannot disable its own supervisor. It drives the manager's active-high reset. That reset is asserted at power-up and after configuration, and it is held until the input clock is reported stable. The block then waits for the manager's lock flag and raises a qualified "clocks good" output once lock is seen.

After lock, the block watches the lock flag and a four-bit status bus. The status bits are: bit 0 phase-shift overflow, bit 1 input clock stopped, bit 2 synthesized clock stopped, bit 3 feedback clock stopped. The input-stopped flag clears itself when the clock returns, so the block times that flag on its own. A short input-clock stop is tolerated. A stop longer than a parameterized window, a lost lock, a stopped feedback clock or (when that output is in use) a stopped synthesized clock all trigger a fresh reset pulse. If lock is not reached within a timeout after reset release, the block retries the reset and counts the retry.

All timer lengths are counted in reference-clock cycles. The lock flag, the status bus and the stable indication are first passed through two-flop synchronizers.

Top module: `clkmgr_supervisor`

## Requirements
- R1: While `rstN` is low, `mgrReset` is 1, `clocksGood` is 0 and `retryCount` is 0.
- R2: Every `mgrReset` pulse lasts at least RST_LEN reference cycles. RST_LEN is `LONG_RST_CYCLES` when `CALIBRATED`=1 and otherwise `SHORT_RST_CYCLES`, with a floor of 3.
- R3: `mgrReset` is not released while the synchronized `inClkStable` is low. Once it is high and the minimum pulse has elapsed, `mgrReset` falls.
- R4: `clocksGood` is 0 until the synchronized lock flag is high. It rises once lock is seen after reset release.
- R5: When the lock flag falls while `clocksGood` is 1, a reset pulse starts. `clocksGood` falls at the same clock edge that `mgrReset` rises.
- R6: `mgrStatus[3]` (feedback stopped) high while `clocksGood` is 1 starts a reset pulse.
- R7: `mgrStatus[1]` (input clock stopped) high for fewer than `STOP_TOL_CYCLES` synchronized cycles has no effect. Held high longer, it starts a reset pulse.
- R8: `mgrStatus[2]` (synthesized clock stopped) starts a reset pulse only when `FX_USED`=1. When `FX_USED`=0 it has no effect.
- R9: `mgrStatus[0]` (phase-shift overflow) has no effect on any output.
- R10: If the lock flag is not seen within `LOCK_WAIT_CYCLES` after reset release, a new reset pulse starts and `retryCount` increments. `retryCount` saturates at all ones.
- R11: An input change on `inClkStable`, `mgrLocked` or `mgrStatus` acts on the outputs at the third rising edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Active-low power-up / configuration reset, asynchronous |
| inClkStable | input | 1 | Indication that the manager's input clock is stable |
| mgrLocked | input | 1 | Manager lock flag, asynchronous |
| mgrStatus | input | 4 | Manager status: [0] phase overflow, [1] input stopped, [2] synthesized stopped, [3] feedback stopped |
| mgrReset | output | 1 | Active-high reset to the clock manager |
| clocksGood | output | 1 | Registered qualified clock-valid flag |
| retryCount | output | RETRY_W | Saturating count of lock-timeout retries |

## Verification
The assertions check on every cycle that the outputs are correct during reset and that each reset pulse meets the minimum length. On every cycle they also check the input history behind each reset release and each rise of `clocksGood`, that `clocksGood` falls only into a reset, and that `retryCount` only steps by one during a reset. The bench's scenarios are needed for the rest. These are the tolerance of short input-clock stops against long ones, the parameter-dependent masking of the synthesized-clock flag, the phase-overflow bit having no effect, the exact three-edge synchronizer latency, and saturation of the retry counter over repeated lock timeouts.

// File: rtl/clkmgr_sup_pkg.sv
package clkmgr_sup_pkg;
  typedef enum logic [1:0] {ST_HOLD, ST_WAIT, ST_RUN} supState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic holdActive;
    logic waitActive;
    logic retryInc;
  } ctlStrobe_t;

  // datapath -> control flags
  typedef struct packed {
    logic stableS;
    logic lockS;
    logic fxStopS;
    logic fbStopS;
    logic rstDone;
    logic lockTimeout;
    logic stopLong;
  } dpFlags_t;
endpackage

// File: rtl/clkmgr_sup_dp.sv
module clkmgr_sup_dp
  import clkmgr_sup_pkg::*;
#(
  parameter int RST_LEN   = 3,
  parameter int STOP_TOL  = 20,
  parameter int LOCK_WAIT = 30,
  parameter int RETRY_W   = 4
) (
  input  logic               refClk,
  input  logic               rstN,
  input  logic               inClkStable,
  input  logic               mgrLocked,
  input  logic [3:1]         statusHi,
  input  ctlStrobe_t         strobe,
  output dpFlags_t           flags,
  output logic [RETRY_W-1:0] retryCount
);
  localparam int SYNC_W  = 5;
  localparam int RST_CW  = $clog2(RST_LEN + 1);
  localparam int STOP_CW = $clog2(STOP_TOL + 1);
  localparam int LOCK_CW = $clog2(LOCK_WAIT + 1);

  logic [SYNC_W-1:0] rawIn, syncOut;
  assign rawIn = {statusHi, mgrLocked, inClkStable};

  generate
    for (genvar i = 0; i < SYNC_W; i++) begin : g_sync
      logic stageA, stageB;
      always_ff @(posedge refClk or negedge rstN) begin
        if (!rstN) begin
          stageA <= 1'b0;
          stageB <= 1'b0;
        end else begin
          stageA <= rawIn[i];
          stageB <= stageA;
        end
      end
      assign syncOut[i] = stageB;
    end
  endgenerate

  logic [RST_CW-1:0]  rstCnt;
  logic [STOP_CW-1:0] stopCnt;
  logic [LOCK_CW-1:0] lockCnt;
  logic [RETRY_W-1:0] retryQ;
  logic rstDone, lockTimeout, stopLong;

  assign rstDone     = int'(rstCnt) >= RST_LEN - 1;
  assign lockTimeout = int'(lockCnt) >= LOCK_WAIT - 1;
  assign stopLong    = int'(stopCnt) >= STOP_TOL;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      rstCnt  <= '0;
      stopCnt <= '0;
      lockCnt <= '0;
      retryQ  <= '0;
    end else begin
      if (!strobe.holdActive)  rstCnt <= '0;
      else if (!rstDone)       rstCnt <= rstCnt + RST_CW'(1);

      if (!strobe.waitActive)  lockCnt <= '0;
      else if (!lockTimeout)   lockCnt <= lockCnt + LOCK_CW'(1);

      if (!syncOut[2])         stopCnt <= '0;
      else if (!stopLong)      stopCnt <= stopCnt + STOP_CW'(1);

      if (strobe.retryInc && retryQ != '1) retryQ <= retryQ + RETRY_W'(1);
    end
  end

  always_comb begin
    flags.stableS     = syncOut[0];
    flags.lockS       = syncOut[1];
    flags.fxStopS     = syncOut[3];
    flags.fbStopS     = syncOut[4];
    flags.rstDone     = rstDone;
    flags.lockTimeout = lockTimeout;
    flags.stopLong    = stopLong;
  end

  assign retryCount = retryQ;
endmodule

// File: rtl/clkmgr_sup_ctrl.sv
module clkmgr_sup_ctrl
  import clkmgr_sup_pkg::*;
#(
  parameter bit FX_USED = 1'b1
) (
  input  logic       refClk,
  input  logic       rstN,
  input  dpFlags_t   flags,
  output ctlStrobe_t strobe,
  output logic       mgrReset,
  output logic       clocksGood
);
  supState_t state, stateNext;
  logic fault, retryNow;

  assign fault = !flags.lockS || flags.fbStopS || flags.stopLong ||
                 (FX_USED && flags.fxStopS);

  always_comb begin
    stateNext = state;
    retryNow  = 1'b0;
    unique case (state)
      ST_HOLD: if (flags.rstDone && flags.stableS) stateNext = ST_WAIT;
      ST_WAIT: begin
        if (flags.lockS) stateNext = ST_RUN;
        else if (flags.lockTimeout) begin
          stateNext = ST_HOLD;
          retryNow  = 1'b1;
        end
      end
      ST_RUN:  if (fault) stateNext = ST_HOLD;
      default: stateNext = ST_HOLD;
    endcase
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.holdActive = (state == ST_HOLD);
    strobe.waitActive = (state == ST_WAIT);
    strobe.retryInc   = retryNow;
  end

  assign mgrReset   = (state == ST_HOLD);
  assign clocksGood = (state == ST_RUN);
endmodule

// File: rtl/clkmgr_supervisor.sv
module clkmgr_supervisor
  import clkmgr_sup_pkg::*;
#(
  parameter bit CALIBRATED       = 1'b0,
  parameter int SHORT_RST_CYCLES = 3,
  parameter int LONG_RST_CYCLES  = 10_000_000,
  parameter int STOP_TOL_CYCLES  = 5_000_000,
  parameter int LOCK_WAIT_CYCLES = 1_000_000,
  parameter int RETRY_W          = 4,
  parameter bit FX_USED          = 1'b1
) (
  input  logic               refClk,
  input  logic               rstN,
  input  logic               inClkStable,
  input  logic               mgrLocked,
  input  logic [3:0]         mgrStatus,
  output logic               mgrReset,
  output logic               clocksGood,
  output logic [RETRY_W-1:0] retryCount
);
  localparam int SHORT_EFF = (SHORT_RST_CYCLES < 3) ? 3 : SHORT_RST_CYCLES;
  localparam int RST_LEN   = CALIBRATED ? LONG_RST_CYCLES : SHORT_EFF;

  ctlStrobe_t strobe;
  dpFlags_t   flags;

  // phase-shift overflow is deliberately not acted upon
  logic unusedOvf;
  assign unusedOvf = mgrStatus[0];

  clkmgr_sup_dp #(
    .RST_LEN  (RST_LEN),
    .STOP_TOL (STOP_TOL_CYCLES),
    .LOCK_WAIT(LOCK_WAIT_CYCLES),
    .RETRY_W  (RETRY_W)
  ) u_dp (
    .refClk     (refClk),
    .rstN       (rstN),
    .inClkStable(inClkStable),
    .mgrLocked  (mgrLocked),
    .statusHi   (mgrStatus[3:1]),
    .strobe     (strobe),
    .flags      (flags),
    .retryCount (retryCount)
  );

  clkmgr_sup_ctrl #(
    .FX_USED(FX_USED)
  ) u_ctrl (
    .refClk    (refClk),
    .rstN      (rstN),
    .flags     (flags),
    .strobe    (strobe),
    .mgrReset  (mgrReset),
    .clocksGood(clocksGood)
  );
endmodule

// File: rtl/clkmgr_supervisor_chk.sv
module clkmgr_supervisor_chk #(
  parameter int RST_LEN = 3,
  parameter int RETRY_W = 4
) (
  input logic               refClk,
  input logic               rstN,
  input logic               inClkStable,
  input logic               mgrLocked,
  input logic               mgrReset,
  input logic               clocksGood,
  input logic [RETRY_W-1:0] retryCount
);
  localparam int HI_W = $clog2(RST_LEN + 1) + 1;
  logic [HI_W-1:0] hiCnt;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                      hiCnt <= '0;
    else if (!mgrReset)             hiCnt <= '0;
    else if (int'(hiCnt) < RST_LEN) hiCnt <= hiCnt + HI_W'(1);
  end

  always_ff @(posedge refClk) begin
    if (!rstN) begin
      AST_RESET_OUTPUTS: assert (mgrReset && !clocksGood && retryCount == '0); // R1
    end
  end

  AST_MIN_PULSE: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(mgrReset) |-> int'(hiCnt) >= RST_LEN); // R2

  AST_RELEASE_NEEDS_STABLE: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(mgrReset) |-> $past(inClkStable, 3)); // R3

  AST_GOOD_NEEDS_LOCK: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(clocksGood) |-> $past(mgrLocked, 3)); // R4

  AST_GOOD_DROP_INTO_RESET: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(clocksGood) |-> mgrReset); // R5

  AST_RETRY_STEP: assert property (@(posedge refClk) disable iff (!rstN)
    !$stable(retryCount) |-> (retryCount == $past(retryCount) + RETRY_W'(1)) && mgrReset); // R10
endmodule

bind clkmgr_supervisor clkmgr_supervisor_chk #(
  .RST_LEN(RST_LEN),
  .RETRY_W(RETRY_W)
) u_chk (
  .refClk     (refClk),
  .rstN       (rstN),
  .inClkStable(inClkStable),
  .mgrLocked  (mgrLocked),
  .mgrReset   (mgrReset),
  .clocksGood (clocksGood),
  .retryCount (retryCount)
);

// File: tb/clkmgr_supervisor_bench.sv
`timescale 1ns/1ps
module clkmgr_supervisor_bench;
  localparam int SHORT = 3;
  localparam int LONG  = 12;
  localparam int TOL   = 20;
  localparam int LW    = 30;
  localparam int RW    = 2;

  logic refClk = 1'b0;
  logic rstN = 1'b0;
  logic inClkStable = 1'b0;
  logic mgrLocked = 1'b0;
  logic [3:0] mgrStatus = 4'h0;
  logic mReset, mGood, aReset, aGood;
  logic [RW-1:0] mRetry, aRetry;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #10 refClk = ~refClk; // 50 MHz

  // main: short pulse, synthesized output used
  clkmgr_supervisor #(
    .CALIBRATED(1'b0), .SHORT_RST_CYCLES(SHORT), .LONG_RST_CYCLES(LONG),
    .STOP_TOL_CYCLES(TOL), .LOCK_WAIT_CYCLES(LW), .RETRY_W(RW), .FX_USED(1'b1)
  ) u_clkmgr_supervisor (
    .refClk(refClk), .rstN(rstN), .inClkStable(inClkStable), .mgrLocked(mgrLocked),
    .mgrStatus(mgrStatus), .mgrReset(mReset), .clocksGood(mGood), .retryCount(mRetry)
  );

  // alternate: calibrated long pulse, synthesized output unused
  clkmgr_supervisor #(
    .CALIBRATED(1'b1), .SHORT_RST_CYCLES(SHORT), .LONG_RST_CYCLES(LONG),
    .STOP_TOL_CYCLES(TOL), .LOCK_WAIT_CYCLES(LW), .RETRY_W(RW), .FX_USED(1'b0)
  ) u_clkmgr_supervisor_alt (
    .refClk(refClk), .rstN(rstN), .inClkStable(inClkStable), .mgrLocked(mgrLocked),
    .mgrStatus(mgrStatus), .mgrReset(aReset), .clocksGood(aGood), .retryCount(aRetry)
  );

  // independent pulse monitors (count completed reset pulses and their widths)
  int mRun = 0, mLast = 0, mPulses = 0;
  int aRun = 0, aLast = 0, aPulses = 0;
  always @(negedge refClk) begin
    if (rstN) begin
      if (mReset) mRun++;
      else begin
        if (mRun > 0) begin mLast = mRun; mPulses++; end
        mRun = 0;
      end
      if (aReset) aRun++;
      else begin
        if (aRun > 0) begin aLast = aRun; aPulses++; end
        aRun = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge refClk);
    @(negedge refClk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
  endtask

  task automatic t_reset_state();
    tick(2);
    check(mReset == 1'b1, "R1 reset out", int'(mReset), 1);
    check(mGood == 1'b0, "R1 good", int'(mGood), 0);
    check(mRetry == '0, "R1 retry", int'(mRetry), 0);
  endtask

  task automatic t_hold_until_stable();
    rstN = 1'b1;
    tick(20);
    check(mReset && aReset, "R3 held while unstable", int'(mReset), 1);
    inClkStable = 1'b1;
    tick(2);
    check(mReset == 1'b1, "R11 stable latency", int'(mReset), 1);
    tick(1);
    check(mReset == 1'b0, "R3 release main", int'(mReset), 0);
    check(aReset == 1'b0, "R3 release alt", int'(aReset), 0);
  endtask

  task automatic t_lock_up();
    check(mGood == 1'b0, "R4 no lock no good", int'(mGood), 0);
    mgrLocked = 1'b1;
    tick(2);
    check(mGood == 1'b0, "R11 lock latency", int'(mGood), 0);
    tick(1);
    check(mGood == 1'b1, "R4 good after lock", int'(mGood), 1);
    tick(5);
    check(aGood == 1'b1, "R4 alt good", int'(aGood), 1);
  endtask

  task automatic t_overflow_ignored();
    bit allOk = 1'b1;
    mgrStatus[0] = 1'b1;
    for (int i = 0; i < 12; i++) begin
      tick(1);
      if (!mGood || mReset || !aGood) allOk = 1'b0;
    end
    mgrStatus[0] = 1'b0;
    tick(4);
    check(allOk && mGood, "R9 overflow no effect", int'(allOk), 1);
  endtask

  task automatic t_input_stop();
    int p0 = mPulses;
    bit allOk = 1'b1;
    mgrStatus[1] = 1'b1;
    for (int i = 0; i < 15; i++) begin
      tick(1);
      if (!mGood || mReset) allOk = 1'b0;
    end
    mgrStatus[1] = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      if (!mGood || mReset) allOk = 1'b0;
    end
    check(allOk, "R7 short stop tolerated", int'(allOk), 1);
    check(mPulses == p0, "R7 short stop no pulse", mPulses, p0);
    mgrStatus[1] = 1'b1;
    tick(26);
    mgrStatus[1] = 1'b0;
    tick(40);
    check(mPulses > p0, "R7 long stop pulse", mPulses, p0 + 1);
    check(mLast >= SHORT, "R2 main width", mLast, SHORT);
    check(mGood == 1'b1, "R7 recovered", int'(mGood), 1);
  endtask

  task automatic t_feedback_stop();
    int p0 = mPulses;
    mgrStatus[3] = 1'b1;
    tick(1);
    mgrStatus[3] = 1'b0;
    tick(1);
    check(mGood == 1'b1, "R11 fb latency", int'(mGood), 1);
    tick(1);
    check(mReset && !mGood, "R6 fb stop reset", int'(mReset), 1);
    tick(40);
    check(mPulses == p0 + 1, "R6 one pulse", mPulses, p0 + 1);
    check(mGood && aGood, "R6 recovered", int'(mGood), 1);
  endtask

  task automatic t_fx_stop();
    int p0 = mPulses;
    int a0 = aPulses;
    mgrStatus[2] = 1'b1;
    tick(1);
    mgrStatus[2] = 1'b0;
    tick(2);
    check(mReset && !mGood, "R8 fx used reset", int'(mReset), 1);
    check(aGood && !aReset, "R8 fx unused ignored", int'(aGood), 1);
    tick(40);
    check(mPulses == p0 + 1, "R8 main pulse", mPulses, p0 + 1);
    check(aPulses == a0, "R8 alt no pulse", aPulses, a0);
  endtask

  task automatic t_lock_loss_retry();
    mgrLocked = 1'b0;
    tick(2);
    check(mGood == 1'b1, "R11 lock loss latency", int'(mGood), 1);
    tick(1);
    check(mReset && !mGood, "R5 good drops with reset", int'(mGood), 0);
    tick(27); // edge 30 after the change
    check(mRetry == 2'd0, "R10 before timeout", int'(mRetry), 0);
    tick(10); // edge 40
    check(mRetry == 2'd1, "R10 first retry", int'(mRetry), 1);
    check(mGood == 1'b0, "R4 no lock no good", int'(mGood), 0);
    tick(200);
    check(mRetry == 2'd3, "R10 saturate main", int'(mRetry), 3);
    check(aRetry == 2'd3, "R10 saturate alt", int'(aRetry), 3);
    check(aLast >= LONG, "R2 calibrated width", aLast, LONG);
    check(mLast >= SHORT, "R2 short width", mLast, SHORT);
    mgrLocked = 1'b1;
    tick(60);
    check(mGood && aGood, "R4 relock", int'(mGood), 1);
    check(mRetry == 2'd3, "R10 held", int'(mRetry), 3);
  endtask

  initial begin
    repeat (20000) @(posedge refClk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_hold_until_stable();
    t_lock_up();
    t_overflow_ignored();
    t_input_stop();
    t_feedback_stop();
    t_fx_stop();
    t_lock_loss_retry();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule